// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block produces the array address for every cycle of a short burst in a synchronous memory. A cycle that asks for a load captures the whole external address. Each following cycle that asks for an advance moves the address to the next beat. The upper address bits stay fixed for the whole burst. Only the low beat bits step, and they follow one of two orders.

The order is chosen by a mode input that is meant to stay static. With the mode high, beat k uses the starting low bits XORed with k. With the mode low, beat k uses the starting low bits plus k, modulo the burst length. The sequence can start at any of the four positions. The beat offset is held in a small counter, so the fifth address of a burst is the first address again.

An active-high hold input freezes the block. While hold is high, loads and advances are both ignored.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is asserted, and until the first load or advance, `addr_o` is zero.
- R2: On a rising clock edge with `hold_i` low and `adv_i` low, the full `addr_i` is captured. From that edge on, `addr_o` equals the captured address, with beat offset 0.
- R3: With `ilv_order_i` = 1, the low two bits of `addr_o` at beat k equal the starting low bits XOR k. For example, a start of 01 gives 01, 00, 11, 10.
- R4: With `ilv_order_i` = 0, the low two bits of `addr_o` at beat k equal (starting low bits + k) mod 4. For example, a start of 01 gives 01, 10, 11, 00.
- R5: The beat offset is two bits wide. After the fourth advance following a load, `addr_o` is again the loaded address.
- R6: During advances, `addr_o[16:2]` keeps the value captured at the load, and `addr_i` has no effect.
- R7: On an edge with `hold_i` high, neither the captured address nor the beat offset changes, whatever `adv_i` and `addr_i` are.
- R8: The low bits of `addr_o` follow `ilv_order_i` without a clock edge. They are computed from the captured start bits and the current offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| hold_i | input | 1 | High freezes all state for this edge |
| adv_i | input | 1 | 1 = advance the beat, 0 = load `addr_i` |
| ilv_order_i | input | 1 | 1 = XOR (interleaved) order, 0 = additive (linear) order |
| addr_i | input | 17 | External address, used on load edges |
| addr_o | output | 17 | Current array address |

## Verification
The only state in this block is the captured base address and the beat offset. Both reach `addr_o` through logic with no registers on the way. A corrupted upper field is therefore visible on the very next cycle. A wrong offset shows up either as the wrong low bits on the next beat, or as a burst that fails to return to its start on the fifth beat. Every starting position is run in both orders, so that an XOR order and an additive order that only happen to agree on some starts are still told apart. The bench also toggles the mode between edges to expose any registered mode path.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

    typedef enum logic {
        ORD_LINEAR      = 1'b0,
        ORD_INTERLEAVED = 1'b1
    } order_e;

    typedef enum logic [1:0] {
        OP_IDLE = 2'b00,
        OP_LOAD = 2'b01,
        OP_STEP = 2'b10
    } op_e;

endpackage

// File: rtl/bseq_beat_ctr.sv
module bseq_beat_ctr #(
    parameter int BEAT_W = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  bseq_pkg::op_e        op_i,
    output logic [BEAT_W-1:0]    beat_o
);
    import bseq_pkg::*;

    localparam logic [BEAT_W-1:0] BEAT_ONE = BEAT_W'(1);

    typedef struct packed {
        logic [BEAT_W-1:0] beat;
    } ctr_s;

    ctr_s ctr_d, ctr_q;

    always_comb begin
        ctr_d = ctr_q;
        case (op_i)
            OP_LOAD: ctr_d.beat = '0;
            OP_STEP: ctr_d.beat = ctr_q.beat + BEAT_ONE;
            default: ctr_d = ctr_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctr_q <= '0;
        else        ctr_q <= ctr_d;
    end

    assign beat_o = ctr_q.beat;

endmodule

// File: rtl/bseq_base_reg.sv
module bseq_base_reg #(
    parameter int ADDR_W = 17,
    parameter int BEAT_W = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  bseq_pkg::op_e            op_i,
    input  logic [ADDR_W-1:0]        addr_i,
    output logic [ADDR_W-BEAT_W-1:0] upper_o,
    output logic [BEAT_W-1:0]        start_o
);
    import bseq_pkg::*;

    localparam int UP_W = ADDR_W - BEAT_W;

    typedef struct packed {
        logic [UP_W-1:0]   upper;
        logic [BEAT_W-1:0] start;
    } base_s;

    base_s base_d, base_q;

    always_comb begin
        base_d = base_q;
        if (op_i == OP_LOAD) begin
            base_d.upper = addr_i[ADDR_W-1:BEAT_W];
            base_d.start = addr_i[BEAT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) base_q <= '0;
        else        base_q <= base_d;
    end

    assign upper_o = base_q.upper;
    assign start_o = base_q.start;

endmodule

// File: rtl/bseq_order_map.sv
module bseq_order_map #(
    parameter int BEAT_W = 2
) (
    input  bseq_pkg::order_e     order_i,
    input  logic [BEAT_W-1:0]    start_i,
    input  logic [BEAT_W-1:0]    beat_i,
    output logic [BEAT_W-1:0]    low_o
);
    import bseq_pkg::*;

    logic [BEAT_W-1:0] xor_low;
    logic [BEAT_W-1:0] add_low;

    for (genvar b = 0; b < BEAT_W; b++) begin : g_xor
        assign xor_low[b] = start_i[b] ^ beat_i[b];
    end

    assign add_low = start_i + beat_i;

    always_comb begin
        case (order_i)
            ORD_INTERLEAVED: low_o = xor_low;
            default:         low_o = add_low;
        endcase
    end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq #(
    parameter int ADDR_W = 17,
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold_i,
    input  logic              adv_i,
    input  logic              ilv_order_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ADDR_W-1:0] addr_o
);
    import bseq_pkg::*;

    localparam int UP_W = ADDR_W - BEAT_W;

    op_e                op;
    order_e             order;
    logic [UP_W-1:0]    upper;
    logic [BEAT_W-1:0]  start;
    logic [BEAT_W-1:0]  beat;
    logic [BEAT_W-1:0]  low;

    always_comb begin
        if (hold_i)     op = OP_IDLE;
        else if (adv_i) op = OP_STEP;
        else            op = OP_LOAD;
    end

    assign order = order_e'(ilv_order_i);

    bseq_beat_ctr #(.BEAT_W(BEAT_W)) u_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .op_i   (op),
        .beat_o (beat)
    );

    bseq_base_reg #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_base (
        .clk     (clk),
        .rst_n   (rst_n),
        .op_i    (op),
        .addr_i  (addr_i),
        .upper_o (upper),
        .start_o (start)
    );

    bseq_order_map #(.BEAT_W(BEAT_W)) u_map (
        .order_i (order),
        .start_i (start),
        .beat_i  (beat),
        .low_o   (low)
    );

    assign addr_o = {upper, low};

endmodule

// File: rtl/bseq_chk.sv
module bseq_chk #(
    parameter int ADDR_W = 17,
    parameter int BEAT_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hold_i,
    input logic              adv_i,
    input logic              ilv_order_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic [ADDR_W-1:0] addr_o
);
    logic [BEAT_W-1:0] sh_start;
    logic [BEAT_W-1:0] sh_k;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_start <= '0;
            sh_k     <= '0;
        end else if (!hold_i) begin
            if (!adv_i) begin
                sh_start <= addr_i[BEAT_W-1:0];
                sh_k     <= '0;
            end else begin
                sh_k <= sh_k + 1'b1;
            end
        end
    end

    // R2
    load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_i && !adv_i) |=> addr_o[ADDR_W-1:BEAT_W] == $past(addr_i[ADDR_W-1:BEAT_W]));

    // R3
    xor_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ilv_order_i |-> addr_o[BEAT_W-1:0] == (sh_start ^ sh_k));

    // R4
    add_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ilv_order_i |-> addr_o[BEAT_W-1:0] == BEAT_W'(sh_start + sh_k));

    // R6
    upper_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_i && adv_i) |=> $stable(addr_o[ADDR_W-1:BEAT_W]));

    // R7
    hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |=> (ilv_order_i != $past(ilv_order_i)) || (addr_o == $past(addr_o)));

endmodule

bind burst_addr_seq bseq_chk #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_bseq_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .hold_i      (hold_i),
    .adv_i       (adv_i),
    .ilv_order_i (ilv_order_i),
    .addr_i      (addr_i),
    .addr_o      (addr_o)
);

// File: tb/test_burst_addr_seq.sv
module test_burst_addr_seq;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 17;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          hold_i = 1'b0;
    logic          adv_i = 1'b1;
    logic          ilv_order_i = 1'b1;
    logic [AW-1:0] addr_i = '0;
    logic [AW-1:0] addr_o;

    int n_chk = 0;
    int n_fail = 0;
    int m_up = 0, m_st = 0, m_k = 0;

    burst_addr_seq i_burst_addr_seq (
        .clk(clk), .rst_n(rst_n), .hold_i(hold_i), .adv_i(adv_i),
        .ilv_order_i(ilv_order_i), .addr_i(addr_i), .addr_o(addr_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [AW-1:0] model_addr();
        int low;
        low = ilv_order_i ? (m_st ^ m_k) : ((m_st + m_k) % 4);
        return AW'((m_up << 2) | low);
    endfunction

    task automatic chk(string tag, logic [AW-1:0] exp);
        n_chk++;
        if (addr_o !== exp) begin
            n_fail++;
            $display("FAIL %s addr_o=%h expected=%h", tag, addr_o, exp);
        end
    endtask

    task automatic step(bit h, bit a, int ad, string tag);
        hold_i = h; adv_i = a; addr_i = AW'(ad);
        @(posedge clk);
        if (!h) begin
            if (!a) begin
                m_up = (ad >> 2) & 32'h7fff; m_st = ad & 3; m_k = 0;
            end else m_k = (m_k + 1) % 4;
        end
        @(negedge clk);
        chk(tag, model_addr());
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired addr_o=%h expected=finish", addr_o);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int xs[4];
        int ls[4];
        xs = '{1, 0, 3, 2};
        ls = '{1, 2, 3, 0};
        repeat (3) @(negedge clk);
        chk("R1 reset", '0);
        rst_n = 1'b1;
        step(0, 1, 'h1fff0, "R1 advance after reset");

        // R3 literal sequence, start 01, with R5 wrap
        ilv_order_i = 1'b1;
        step(0, 0, 'h12345, "R2 load");
        for (int i = 1; i < 4; i++) begin
            step(0, 1, 'h0aaaa, "R3 interleaved");
            chk("R3 literal", AW'('h12344 | xs[i]));
        end
        step(0, 1, 'h0, "R5 wrap interleaved");
        chk("R5 literal", AW'('h12345));

        // R4 literal sequence, start 01
        ilv_order_i = 1'b0;
        step(0, 0, 'h0f0f1, "R2 load linear");
        for (int i = 1; i < 4; i++) begin
            step(0, 1, 'h1ffff, "R4 linear");
            chk("R4 literal", AW'('h0f0f0 | ls[i]));
        end
        step(0, 1, 'h0, "R5 wrap linear");
        chk("R5 literal linear", AW'('h0f0f1));

        // every start in both orders, R6 with changing addr_i
        for (int md = 0; md < 2; md++) begin
            ilv_order_i = md[0];
            for (int s = 0; s < 4; s++) begin
                step(0, 0, 'h15550 + s * 5 - (s * 5 % 4) + s, "R2 load start");
                for (int b = 0; b < 5; b++)
                    step(0, 1, 'h0ffff ^ (b * 'h1111), md ? "R3 R6 sweep" : "R4 R6 sweep");
            end
        end

        // R7 hold freezes load and advance
        ilv_order_i = 1'b0;
        step(0, 0, 'h00402, "R2 load");
        step(0, 1, 'h0, "R4 beat1");
        step(1, 0, 'h1ffff, "R7 hold with load");
        chk("R7 literal", AW'('h00403));
        step(1, 1, 'h0, "R7 hold with advance");
        step(0, 1, 'h0, "R7 resume");
        chk("R7 resume literal", AW'('h00400));

        // R8 mode follows without clock
        step(0, 0, 'h08881, "R2 load");
        step(0, 1, 'h0, "R4 k1");
        chk("R8 linear literal", AW'('h08882));
        #1 ilv_order_i = 1'b1;
        #1 chk("R8 interleaved literal", AW'('h08880));
        #1 ilv_order_i = 1'b0;
        #1 chk("R8 back to linear", AW'('h08882));

        // R1 reset mid burst
        @(negedge clk);
        rst_n = 1'b0;
        #1 chk("R1 async reset", '0);
        m_up = 0; m_st = 0; m_k = 0;
        @(negedge clk);
        rst_n = 1'b1;
        step(0, 1, 'h0, "R1 advance from reset");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule